// File: doc/BRIEF.md
# Iterative Tree Sum Reduction Engine

This block adds up a bank of integer partial sums, one per virtual processor slot, by repeated halving. The host first writes each slot through a load port (index and value), then pulses a start input. On every following clock edge the engine performs one reduction step across the whole bank at once. It computes the new active length as half the current one, rounded down. Each slot below that new length adds in the entry the same distance above it. When the current length is odd, slot 0 also absorbs the last active entry in the same step, so any slot count works and not only powers of two. Each step is a single registered update of the whole bank, so every slot finishes a step before any slot starts the next without any explicit barrier.

The run ends when the active length reaches one. At that point a done flag pulses and the total appears on the result output, where it stays until the next accepted start. The slot count and operand width are parameters. Additions are unsigned and wrap modulo 2^DATA_W.

Top module: `tree_sum_reducer`

## Requirements
- R1: After reset, busy and done are 0 and result is 0.
- R2: A load pulse while busy is 0 writes load_val into the slot named by load_idx; an index equal to or above N_SLOTS changes no slot.
- R3: When a run ends, result equals the sum of all N_SLOTS slot values as they stood at start, wrapped modulo 2^DATA_W.
- R4: In any step where the active length h is odd, slot 0 also adds the pre-step value of slot h-1, in the same cycle as the pairwise additions, so odd lengths (e.g. 100, 25, 3) reduce correctly.
- R5: For N_SLOTS > 1, busy is 1 from the edge that accepts start for exactly floor(log2 N_SLOTS) cycles. Done rises at the edge that ends the last step.
- R6: done is high for exactly one cycle per run and is never high together with busy.
- R7: result holds its value from the end of a run until the next accepted start, whatever the loads in between.
- R8: A start pulse while busy is 1 is ignored: the run neither restarts nor changes its step count.
- R9: A load pulse while busy is 1 changes no slot and does not alter the run's result.
- R10: With N_SLOTS = 1, an accepted start raises done at the next edge without raising busy, and result equals slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Write strobe for the slot bank |
| load_idx | input | IDX_W | Slot index for a write |
| load_val | input | DATA_W | Value written to the slot |
| start | input | 1 | Begin a reduction run |
| busy | output | 1 | Reduction steps in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| result | output | DATA_W | Total of the last completed run |

## Verification
Start is sampled on a rising edge. busy is then visible one cycle later, and done with a valid result comes floor(log2 N) edges after the accepting edge: 4 for 16 slots, 6 for 100 and 0 for a single slot, where done appears at that same edge. The bench drives inputs and samples outputs on falling edges. After each start it walks cycle by cycle and requires busy to be high exactly on the predicted cycles and done exactly on the predicted one. It then compares result against a sum it forms itself. Starts and loads injected in the middle of a run are checked against the same predicted cycles and totals.

// File: rtl/tsr_pkg.sv
package tsr_pkg;

  // Active length after one halving step (integer division by two).
  function automatic int unsigned halve_len(input int unsigned len);
    return len / 2;
  endfunction

  // An odd active length requires slot 0 to absorb its last element.
  function automatic bit odd_len(input int unsigned len);
    return (len % 2) == 1;
  endfunction

  // Number of halving steps needed to bring a length down to one.
  function automatic int unsigned step_count(input int unsigned len);
    int unsigned h;
    int unsigned s;
    h = len;
    s = 0;
    while (h > 1) begin
      h = h / 2;
      s = s + 1;
    end
    return s;
  endfunction

endpackage

// File: rtl/tsr_ctrl.sv
module tsr_ctrl #(
  parameter int N_SLOTS = 16,
  localparam int CNT_W = $clog2(N_SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic             done,
  output logic             step_en,
  output logic             fold_en,
  output logic [CNT_W-1:0] cur_half,
  output logic [CNT_W-1:0] next_half,
  output logic             finish
);
  logic [CNT_W-1:0] half_q;
  logic             busy_q;
  logic             done_q;
  logic             start_ok;
  logic             last_step;

  always_comb begin
    cur_half  = half_q;
    next_half = CNT_W'(tsr_pkg::halve_len(32'(half_q)));
    step_en   = busy_q;
    fold_en   = busy_q && tsr_pkg::odd_len(32'(half_q));
    start_ok  = start && !busy_q;
    last_step = busy_q && (next_half == CNT_W'(1));
    finish    = last_step || (start_ok && (N_SLOTS == 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= finish;
      if (busy_q) begin
        half_q <= next_half;
        if (last_step) busy_q <= 1'b0;
      end else if (start_ok && (N_SLOTS > 1)) begin
        half_q <= CNT_W'(N_SLOTS);
        busy_q <= 1'b1;
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;

endmodule

// File: rtl/tsr_bank.sv
module tsr_bank #(
  parameter int N_SLOTS = 16,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1,
  localparam int CNT_W  = $clog2(N_SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [IDX_W-1:0]  load_idx,
  input  logic [DATA_W-1:0] load_val,
  input  logic              step_en,
  input  logic              fold_en,
  input  logic [CNT_W-1:0]  cur_half,
  input  logic [CNT_W-1:0]  next_half,
  output logic [DATA_W-1:0] sum0_next
);
  logic [DATA_W-1:0] slots     [N_SLOTS];
  logic [DATA_W-1:0] slot_next [N_SLOTS];
  logic [DATA_W-1:0] fold_val;

  // Last active element, absorbed by slot 0 when the length is odd.
  always_comb begin
    fold_val = '0;
    if (fold_en) fold_val = slots[IDX_W'(int'(cur_half) - 1)];
  end

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_lane
    logic [DATA_W-1:0] partner;
    int unsigned       pidx;

    always_comb begin
      pidx    = g + 32'(next_half);
      partner = '0;
      if (step_en && (g < int'(next_half)) && (pidx < N_SLOTS))
        partner = slots[IDX_W'(pidx)];
    end

    if (g == 0) begin : g_head
      always_comb slot_next[g] = slots[g] + partner + fold_val;
    end else begin : g_body
      always_comb slot_next[g] = slots[g] + partner;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slots[g] <= '0;
      end else if (step_en) begin
        slots[g] <= slot_next[g];
      end else if (load_en && (32'(load_idx) == g)) begin
        slots[g] <= load_val;
      end
    end
  end

  assign sum0_next = slot_next[0];

endmodule

// File: rtl/tree_sum_reducer.sv
module tree_sum_reducer #(
  parameter int N_SLOTS = 16,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1,
  localparam int CNT_W  = $clog2(N_SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [IDX_W-1:0]  load_idx,
  input  logic [DATA_W-1:0] load_val,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] result
);
  logic              step_en_w;
  logic              fold_en_w;
  logic [CNT_W-1:0]  cur_half_w;
  logic [CNT_W-1:0]  next_half_w;
  logic              finish_w;
  logic [DATA_W-1:0] sum0_next_w;
  logic [DATA_W-1:0] result_q;

  tsr_ctrl #(.N_SLOTS(N_SLOTS)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .step_en   (step_en_w),
    .fold_en   (fold_en_w),
    .cur_half  (cur_half_w),
    .next_half (next_half_w),
    .finish    (finish_w)
  );

  tsr_bank #(.N_SLOTS(N_SLOTS), .DATA_W(DATA_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_en),
    .load_idx  (load_idx),
    .load_val  (load_val),
    .step_en   (step_en_w),
    .fold_en   (fold_en_w),
    .cur_half  (cur_half_w),
    .next_half (next_half_w),
    .sum0_next (sum0_next_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) result_q <= '0;
    else if (finish_w) result_q <= sum0_next_w;
  end

  assign result = result_q;

endmodule

// File: rtl/tsr_checker.sv
module tsr_checker #(
  parameter int N_SLOTS = 16,
  parameter int DATA_W  = 32,
  localparam int CNT_W  = $clog2(N_SLOTS + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] result,
  input logic              finish,
  input logic [CNT_W-1:0]  cur_half
);

  assert_done_not_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !done);

  assert_finish_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> (done && !busy));

  assert_halving_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !finish) |=> (busy && (cur_half == ($past(cur_half) >> 1))));

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (done || (cur_half == ($past(cur_half) >> 1))));

  assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !finish |=> $stable(result));

endmodule

bind tree_sum_reducer tsr_checker #(.N_SLOTS(N_SLOTS), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .result   (result),
  .finish   (finish_w),
  .cur_half (cur_half_w)
);

// File: tb/tb_tree_sum_reducer.sv
`timescale 1ns/1ps
module tb_tree_sum_reducer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int failures = 0;

  // 16-slot instance
  logic ld_a = 0, st_a = 0; logic [3:0] ix_a = 0; logic [31:0] v_a = 0;
  logic bz_a, dn_a; logic [31:0] rs_a;
  // 100-slot instance
  logic ld_b = 0, st_b = 0; logic [6:0] ix_b = 0; logic [31:0] v_b = 0;
  logic bz_b, dn_b; logic [31:0] rs_b;
  // 1-slot instance
  logic ld_c = 0, st_c = 0; logic [0:0] ix_c = 0; logic [31:0] v_c = 0;
  logic bz_c, dn_c; logic [31:0] rs_c;

  tree_sum_reducer #(.N_SLOTS(16)) dut (
    .clk(clk), .rst_n(rst_n), .load_en(ld_a), .load_idx(ix_a), .load_val(v_a),
    .start(st_a), .busy(bz_a), .done(dn_a), .result(rs_a));
  tree_sum_reducer #(.N_SLOTS(100)) dut100 (
    .clk(clk), .rst_n(rst_n), .load_en(ld_b), .load_idx(ix_b), .load_val(v_b),
    .start(st_b), .busy(bz_b), .done(dn_b), .result(rs_b));
  tree_sum_reducer #(.N_SLOTS(1)) dut1 (
    .clk(clk), .rst_n(rst_n), .load_en(ld_c), .load_idx(ix_c), .load_val(v_c),
    .start(st_c), .busy(bz_c), .done(dn_c), .result(rs_c));

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int steps_of(input int n);
    int s = 0;
    for (int h = n; h > 1; h = h >> 1) s++;
    return s;
  endfunction

  task automatic load(input int which, input int idx, input logic [31:0] val);
    @(negedge clk);
    case (which)
      0: begin ld_a = 1; ix_a = 4'(idx); v_a = val; end
      1: begin ld_b = 1; ix_b = 7'(idx); v_b = val; end
      default: begin ld_c = 1; ix_c = 1'(idx); v_c = val; end
    endcase
    @(negedge clk);
    ld_a = 0; ld_b = 0; ld_c = 0;
  endtask

  // Starts a run, walks it cycle by cycle and checks busy/done/result.
  task automatic run(input int which, input int n, input logic [31:0] exp,
                     input bit inj_start, input bit inj_load, input string tag);
    int s = steps_of(n);
    logic b, d;
    logic [31:0] r;
    @(negedge clk);
    case (which) 0: st_a = 1; 1: st_b = 1; default: st_c = 1; endcase
    for (int k = 1; k <= s + 1; k++) begin
      @(negedge clk);
      st_a = 0; st_b = 0; st_c = 0; ld_a = 0;
      case (which)
        0: begin b = bz_a; d = dn_a; r = rs_a; end
        1: begin b = bz_b; d = dn_b; r = rs_b; end
        default: begin b = bz_c; d = dn_c; r = rs_c; end
      endcase
      check(b == (k <= s), {"R5 busy ", tag}, 32'(b), 32'(k <= s));
      check(d == (k == s + 1), {"R5 done ", tag}, 32'(d), 32'(k == s + 1));
      check(!(b && d), {"R6 exclusive ", tag}, 32'(b), 0);
      if (k == s + 1) check(r == exp, {"R3 total ", tag}, r, exp);
      if (k == 2 && which == 0) begin
        if (inj_start) st_a = 1;                       // R8
        if (inj_load) begin ld_a = 1; ix_a = 0; v_a = 32'hDEAD_0000; end // R9
      end
    end
    @(negedge clk);
    case (which) 0: d = dn_a; 1: d = dn_b; default: d = dn_c; endcase
    check(!d, {"R6 pulse ", tag}, 32'(d), 0);
  endtask

  task automatic t_reset();
    check(!bz_a && !dn_a, "R1 flags", {30'd0, bz_a, dn_a}, 0);
    check(rs_a == 0, "R1 result", rs_a, 0);
  endtask

  task automatic t_basic();
    logic [31:0] e = 0;
    for (int i = 0; i < 16; i++) begin load(0, i, 32'(i + 1)); e += 32'(i + 1); end
    run(0, 16, e, 0, 0, "R2 ascending");
  endtask

  task automatic t_wrap();
    logic [31:0] e = 0;
    for (int i = 0; i < 16; i++) begin
      load(0, i, 32'hF000_0000 + 32'(i * 7)); e += 32'hF000_0000 + 32'(i * 7);
    end
    run(0, 16, e, 0, 0, "wrap");
  endtask

  task automatic t_inject();
    logic [31:0] e = 0;
    for (int i = 0; i < 16; i++) begin load(0, i, 32'(i * i)); e += 32'(i * i); end
    run(0, 16, e, 1, 1, "R8 R9 midrun start and load");
  endtask

  task automatic t_hold();
    logic [31:0] keep = rs_a;
    repeat (4) @(negedge clk);
    load(0, 0, 32'h1234_5678);
    load(0, 5, 32'h0BAD_F00D);
    repeat (2) @(negedge clk);
    check(rs_a == keep, "R7 result held", rs_a, keep);
  endtask

  task automatic t_odd();
    logic [31:0] e = 0;
    for (int i = 0; i < 100; i++) begin load(1, i, 32'(i * 3 + 1)); e += 32'(i * 3 + 1); end
    load(1, 120, 32'h7777_7777);  // R2 out-of-range index ignored
    run(1, 100, e, 0, 0, "R4 odd lengths n=100");
  endtask

  task automatic t_single();
    load(2, 0, 32'hCAFE_0042);
    run(2, 1, 32'hCAFE_0042, 0, 0, "R10 single slot");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_wrap();
    t_inject();
    t_hold();
    t_odd();
    t_single();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule